// File: doc/BRIEF.md
# Configuration Image Cache Loader

This block reloads an SRAM-based programmable device from stored configuration images. A host records where each of three images starts in a small cache memory, then names a slot and issues a start command. The loader pulses the device's program line, waits for the device to report that it is ready for data, and streams the image out one bit per configuration clock.

Every image begins with a two-byte length. The loader reads the image a byte at a time from the cache and shifts each byte out most significant bit first. It then gives the device a bounded time to report completion. If the device raises its error input, misses a deadline, or the host names a slot that does not exist, the loader gives up on that image. It then reloads the known-good base image from address `FLASH_BASE` of the flash store and latches an error flag for the host. If the base image also fails, the loader parks in a fatal state until the next start command.

Top module: `cfg_cache_mgr`

## Requirements
- R1: While reset is asserted and after it is released, cfg_prog_n=1, cfg_cclk=0, cfg_din=0, mem_rd=0, busy=0, loaded=0, fatal=0 and err_flag=0.
- R2: A start with cmd_slot in 0..2 reads the cache (mem_src=0), beginning at the address last written into that slot through tbl_we/tbl_slot/tbl_addr. Writes to tbl_slot=3 have no effect.
- R3: On the clock edge that accepts a start, cfg_prog_n goes low and stays low for PROG_CYC (4) cycles. The loader then waits for cfg_init; if cfg_init does not arrive within WAIT_TMO (64) cycles, the load fails.
- R4: The first two bytes of an image are its byte count, high byte first. A count of zero skips serialization and goes straight to the completion wait.
- R5: Each data byte is sent MSB first. Each bit takes two cycles: cfg_cclk low, then high, with cfg_din held for both. Outside serialization cfg_cclk=0 and cfg_din=0.
- R6: Memory reads are single-cycle mem_rd pulses to consecutive addresses. The data is taken from mem_rdata one cycle after each pulse.
- R7: If cfg_done is high within WAIT_TMO cycles after the last bit, loaded=1 and busy=0.
- R8: A cfg_err high at any point from the wait for cfg_init until completion, or a timeout on either wait, fails a cache load. The loader then sets err_flag and restarts with a program pulse, reading the flash (mem_src=1) from FLASH_BASE.
- R9: A start naming slot 3 sets err_flag and loads the base flash image directly.
- R10: If the base image load fails, fatal=1 and busy=0. A later start leaves the fatal state.
- R11: err_flag stays set until err_clr is high on a clock edge. Setting takes priority over a clear in the same cycle.
- R12: cmd_start is ignored while busy=1.
- R13: busy is high from the cycle after an accepted start until loaded or fatal is reached. At most one of busy, loaded and fatal is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Write a slot start address |
| tbl_slot | input | 2 | Slot written by tbl_we |
| tbl_addr | input | 12 | Start address stored into the slot |
| cmd_start | input | 1 | Start a reconfiguration |
| cmd_slot | input | 2 | Slot to load (3 is invalid) |
| err_clr | input | 1 | Clear the latched error flag |
| mem_rd | output | 1 | Read strobe to the image memories |
| mem_src | output | 1 | 0 = cache, 1 = flash |
| mem_addr | output | 12 | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| cfg_prog_n | output | 1 | Device program line, active low |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init | input | 1 | Device ready for data |
| cfg_done | input | 1 | Device configured |
| cfg_err | input | 1 | Device reports a configuration error |
| busy | output | 1 | Load in progress |
| loaded | output | 1 | Last load succeeded |
| fatal | output | 1 | Base image also failed |
| err_flag | output | 1 | Latched error indication |

## Verification
The hardest situation to reach from the ports is a double failure: a cache image must fail, and then the base image started by the fallback must fail as well. The bench models the device as a per-load script indexed by program pulse, so the first and second loads after a start can be given different behaviour. A silent device on both loads is the path that reaches the fatal state. An error raised at a chosen bit count exercises an abort in the middle of a byte. A clear held high across an invalid-slot start shows that setting the error takes priority over clearing it.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT,
        ST_FETCH,
        ST_CAPT,
        ST_SHIFT,
        ST_WDONE,
        ST_LOADED,
        ST_FATAL
    } seq_state_e;

    localparam logic SRC_CACHE = 1'b0;
    localparam logic SRC_FLASH = 1'b1;
endpackage

// File: rtl/ccm_slot_table.sv
module ccm_slot_table #(
    parameter int SLOTS  = 3,
    parameter int ADDR_W = 12,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] slot_base [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [ADDR_W-1:0] base_d, base_q;

        always_comb begin
            base_d = base_q;
            if (wr_en && (wr_slot == SLOT_W'(g))) base_d = wr_addr;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) base_q <= '0;
            else        base_q <= base_d;
        end

        assign slot_base[g] = base_q;
    end

    always_comb begin
        rd_addr  = '0;
        rd_valid = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_addr  = slot_base[i];
                rd_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccm_serializer.sv
module ccm_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] byte_in,
    input  logic         abort,
    output logic         sclk,
    output logic         sdat,
    output logic         last
);
    localparam int BC_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]    sreg;
        logic            phase;
        logic [BC_W-1:0] bcnt;
        logic            act;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d    = q;
        last = q.act && q.phase && (q.bcnt == BC_W'(W - 1));
        if (abort) begin
            d.act = 1'b0;
        end else if (load) begin
            d.sreg  = byte_in;
            d.phase = 1'b0;
            d.bcnt  = '0;
            d.act   = 1'b1;
        end else if (q.act) begin
            if (!q.phase) begin
                d.phase = 1'b1;
            end else begin
                d.phase = 1'b0;
                d.sreg  = q.sreg << 1;
                d.bcnt  = q.bcnt + 1'b1;
                if (last) d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.act && q.phase;
    assign sdat = q.act ? q.sreg[W-1] : 1'b0;

    // R5: a clock high lasts exactly one cycle
    a_r5_clk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);
    // R5: data is held across the low and high half of a bit
    a_r5_dat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && !q.phase && !abort && !load) |=> $stable(sdat));
endmodule

// File: rtl/ccm_seq.sv
module ccm_seq
    import ccm_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int W          = 8,
    parameter int PROG_CYC   = 4,
    parameter int WAIT_TMO   = 64,
    parameter int FLASH_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              err_clr,
    output logic              mem_rd,
    output logic              mem_src,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [W-1:0]      mem_rdata,
    output logic              prog_n,
    input  logic              dev_init,
    input  logic              dev_done,
    input  logic              dev_err,
    output logic              ser_load,
    output logic [W-1:0]      ser_byte,
    output logic              ser_abort,
    input  logic              ser_last,
    output logic              busy,
    output logic              loaded,
    output logic              fatal,
    output logic              err_flag
);
    localparam int LEN_W = 2 * W;
    localparam int CMAX  = (PROG_CYC > WAIT_TMO) ? PROG_CYC : WAIT_TMO;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              fb;
        logic              err;
        logic              src;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [1:0]        hdr;
    } seq_t;

    seq_t q, d;
    logic fail;
    logic [LEN_W-1:0] len_shift;

    always_comb begin
        d         = q;
        fail      = 1'b0;
        ser_load  = 1'b0;
        ser_byte  = mem_rdata;
        len_shift = {q.len[W-1:0], mem_rdata};
        if (err_clr) d.err = 1'b0;

        case (q.st)
            ST_IDLE, ST_LOADED, ST_FATAL: begin
                if (cmd_start) begin
                    d.st  = ST_PROG;
                    d.cnt = '0;
                    d.hdr = 2'd0;
                    if (slot_valid) begin
                        d.src  = SRC_CACHE;
                        d.addr = slot_addr;
                        d.fb   = 1'b0;
                    end else begin
                        d.src  = SRC_FLASH;
                        d.addr = ADDR_W'(FLASH_BASE);
                        d.fb   = 1'b1;
                        d.err  = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    d.st  = ST_INIT;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_INIT: begin
                if (dev_err)                              fail = 1'b1;
                else if (dev_init)                        d.st = ST_FETCH;
                else if (q.cnt == CNT_W'(WAIT_TMO - 1))   fail = 1'b1;
                else                                      d.cnt = q.cnt + 1'b1;
            end
            ST_FETCH: begin
                if (dev_err) fail = 1'b1;
                else begin
                    d.st   = ST_CAPT;
                    d.addr = q.addr + 1'b1;
                end
            end
            ST_CAPT: begin
                if (dev_err) begin
                    fail = 1'b1;
                end else if (q.hdr != 2'd2) begin
                    d.len = len_shift;
                    d.hdr = q.hdr + 1'b1;
                    if (q.hdr == 2'd1 && len_shift == '0) begin
                        d.st  = ST_WDONE;
                        d.cnt = '0;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end else begin
                    ser_load = 1'b1;
                    d.st     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (dev_err) begin
                    fail = 1'b1;
                end else if (ser_last) begin
                    d.len = q.len - 1'b1;
                    if (q.len == LEN_W'(1)) begin
                        d.st  = ST_WDONE;
                        d.cnt = '0;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_WDONE: begin
                if (dev_err)                              fail = 1'b1;
                else if (dev_done)                        d.st = ST_LOADED;
                else if (q.cnt == CNT_W'(WAIT_TMO - 1))   fail = 1'b1;
                else                                      d.cnt = q.cnt + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (fail) begin
            if (!q.fb) begin
                d.fb   = 1'b1;
                d.src  = SRC_FLASH;
                d.addr = ADDR_W'(FLASH_BASE);
                d.err  = 1'b1;
                d.st   = ST_PROG;
                d.cnt  = '0;
                d.hdr  = 2'd0;
            end else begin
                d.st = ST_FATAL;
            end
        end
        ser_abort = fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign prog_n   = (q.st != ST_PROG);
    assign mem_rd   = (q.st == ST_FETCH);
    assign mem_src  = q.src;
    assign mem_addr = q.addr;
    assign busy     = q.st inside {ST_PROG, ST_INIT, ST_FETCH, ST_CAPT, ST_SHIFT, ST_WDONE};
    assign loaded   = (q.st == ST_LOADED);
    assign fatal    = (q.st == ST_FATAL);
    assign err_flag = q.err;

    // R6: each read strobe lasts one cycle
    a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R6: the next read address follows the previous one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !dev_err) |=> (mem_addr == $past(mem_addr) + 1'b1));
    // R11: the flag holds unless cleared
    a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
    // R10: the fatal state is entered only from an active load
    a_r10_fatal_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal) |-> $past(busy));
    // R13: status outputs are mutually exclusive
    a_r13_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, loaded, fatal}));
endmodule

// File: rtl/cfg_cache_mgr.sv
module cfg_cache_mgr #(
    parameter int SLOTS      = 3,
    parameter int ADDR_W     = 12,
    parameter int WORD_W     = 8,
    parameter int PROG_CYC   = 4,
    parameter int WAIT_TMO   = 64,
    parameter int FLASH_BASE = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tbl_we,
    input  logic [$clog2(SLOTS+1)-1:0]        tbl_slot,
    input  logic [ADDR_W-1:0]                 tbl_addr,
    input  logic                              cmd_start,
    input  logic [$clog2(SLOTS+1)-1:0]        cmd_slot,
    input  logic                              err_clr,
    output logic                              mem_rd,
    output logic                              mem_src,
    output logic [ADDR_W-1:0]                 mem_addr,
    input  logic [WORD_W-1:0]                 mem_rdata,
    output logic                              cfg_prog_n,
    output logic                              cfg_cclk,
    output logic                              cfg_din,
    input  logic                              cfg_init,
    input  logic                              cfg_done,
    input  logic                              cfg_err,
    output logic                              busy,
    output logic                              loaded,
    output logic                              fatal,
    output logic                              err_flag
);
    localparam int SLOT_W = $clog2(SLOTS + 1);

    logic [ADDR_W-1:0] slot_addr;
    logic              slot_valid;
    logic              ser_load, ser_abort, ser_last;
    logic [WORD_W-1:0] ser_byte;

    ccm_slot_table #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_slot(tbl_slot), .wr_addr(tbl_addr),
        .rd_slot(cmd_slot), .rd_addr(slot_addr), .rd_valid(slot_valid)
    );

    ccm_seq #(.ADDR_W(ADDR_W), .W(WORD_W), .PROG_CYC(PROG_CYC),
              .WAIT_TMO(WAIT_TMO), .FLASH_BASE(FLASH_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .slot_valid(slot_valid), .slot_addr(slot_addr),
        .err_clr(err_clr),
        .mem_rd(mem_rd), .mem_src(mem_src), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .prog_n(cfg_prog_n), .dev_init(cfg_init), .dev_done(cfg_done), .dev_err(cfg_err),
        .ser_load(ser_load), .ser_byte(ser_byte), .ser_abort(ser_abort), .ser_last(ser_last),
        .busy(busy), .loaded(loaded), .fatal(fatal), .err_flag(err_flag)
    );

    ccm_serializer #(.W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .load(ser_load), .byte_in(ser_byte), .abort(ser_abort),
        .sclk(cfg_cclk), .sdat(cfg_din), .last(ser_last)
    );

    // R5: no configuration clock outside an active load
    a_r5_clk_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cclk |-> busy);
    // R3: a program pulse only starts while a load is under way
    a_r3_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_prog_n) |-> busy);
endmodule

// File: tb/tb_cfg_cache_mgr.sv
module tb_cfg_cache_mgr;
    localparam int AW = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic tbl_we = 0; logic [1:0] tbl_slot = 0; logic [AW-1:0] tbl_addr = 0;
    logic cmd_start = 0; logic [1:0] cmd_slot = 0; logic err_clr = 0;
    logic mem_rd, mem_src; logic [AW-1:0] mem_addr; logic [7:0] mem_rdata = 0;
    logic cfg_prog_n, cfg_cclk, cfg_din;
    logic cfg_init = 0, cfg_done = 0, cfg_err = 0;
    logic busy, loaded, fatal, err_flag;

    cfg_cache_mgr dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_addr(tbl_addr),
        .cmd_start(cmd_start), .cmd_slot(cmd_slot), .err_clr(err_clr),
        .mem_rd(mem_rd), .mem_src(mem_src), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
        .cfg_init(cfg_init), .cfg_done(cfg_done), .cfg_err(cfg_err),
        .busy(busy), .loaded(loaded), .fatal(fatal), .err_flag(err_flag)
    );

    int checks = 0, errors = 0;
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural image memories
    logic [7:0] cache_m [256];
    logic [7:0] flash_m [256];
    always @(posedge clk)
        if (mem_rd) mem_rdata <= mem_src ? flash_m[mem_addr[7:0]] : cache_m[mem_addr[7:0]];

    // reference model: 0 idle 1 prog 2 init 3 fetch 4 capt 5 shift 6 wdone 7 loaded 8 fatal
    int r_st, r_cnt, r_fb, r_err, r_src, r_addr, r_raddr, r_hdr, r_bit, r_ph, r_fail;
    int r_tbl [3];
    logic [15:0] r_len;
    logic [7:0]  r_byte, r_d;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_st = 0; r_cnt = 0; r_fb = 0; r_err = 0; r_src = 0; r_addr = 0; r_raddr = 0;
            r_hdr = 0; r_bit = 0; r_ph = 0; r_len = 0; r_byte = 0;
            foreach (r_tbl[i]) r_tbl[i] = 0;
        end else begin
            r_fail = 0;
            if (err_clr) r_err = 0;
            if (r_st == 0 || r_st == 7 || r_st == 8) begin
                if (cmd_start) begin
                    r_st = 1; r_cnt = 0; r_hdr = 0;
                    if (cmd_slot < 3) begin r_src = 0; r_addr = r_tbl[cmd_slot]; r_fb = 0; end
                    else begin r_src = 1; r_addr = 0; r_fb = 1; r_err = 1; end
                end
            end else if (r_st == 1) begin
                if (r_cnt == 3) begin r_st = 2; r_cnt = 0; end else r_cnt++;
            end else if (cfg_err) begin
                r_fail = 1;
            end else if (r_st == 2) begin
                if (cfg_init) r_st = 3; else if (r_cnt == 63) r_fail = 1; else r_cnt++;
            end else if (r_st == 3) begin
                r_raddr = r_addr; r_addr = (r_addr + 1) & 12'hfff; r_st = 4;
            end else if (r_st == 4) begin
                r_d = r_src ? flash_m[r_raddr[7:0]] : cache_m[r_raddr[7:0]];
                if (r_hdr < 2) begin
                    r_len = {r_len[7:0], r_d}; r_hdr++;
                    if (r_hdr == 2 && r_len == 0) begin r_st = 6; r_cnt = 0; end else r_st = 3;
                end else begin
                    r_byte = r_d; r_bit = 0; r_ph = 0; r_st = 5;
                end
            end else if (r_st == 5) begin
                if (r_ph == 0) r_ph = 1;
                else begin
                    r_ph = 0; r_byte = r_byte << 1;
                    if (r_bit == 7) begin
                        if (r_len == 1) begin r_st = 6; r_cnt = 0; end else r_st = 3;
                        r_len = r_len - 1;
                    end else r_bit++;
                end
            end else if (r_st == 6) begin
                if (cfg_done) r_st = 7; else if (r_cnt == 63) r_fail = 1; else r_cnt++;
            end
            if (r_fail) begin
                if (r_fb == 0) begin
                    r_fb = 1; r_src = 1; r_addr = 0; r_err = 1; r_st = 1; r_cnt = 0; r_hdr = 0;
                end else r_st = 8;
            end
            if (tbl_we && tbl_slot < 3) r_tbl[tbl_slot] = tbl_addr;
        end
    end

    // device model knobs, per load after a start (index 0 = first, 1 = fallback)
    int init_ok [2], done_ok [2], need [2], err_bit [2];
    int pcount = 0, since = 0, bits = 0, li;
    logic prev_prog = 1;
    bit cmp_en = 0;
    // scenario monitors
    int first_rd, first_src, clk_total, seen_err, hit80;
    logic [63:0] bitacc;

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R3",  "prog_n",   cfg_prog_n, r_st != 1);
            chk("R5",  "cclk",     cfg_cclk,   (r_st == 5 && r_ph == 1));
            chk("R5",  "din",      cfg_din,    (r_st == 5) ? r_byte[7] : 1'b0);
            chk("R13", "busy",     busy,       (r_st >= 1 && r_st <= 6));
            chk("R7",  "loaded",   loaded,     r_st == 7);
            chk("R10", "fatal",    fatal,      r_st == 8);
            chk("R11", "err_flag", err_flag,   r_err != 0);
            chk("R6",  "mem_rd",   mem_rd,     r_st == 3);
            if (mem_rd) begin
                chk("R6", "mem_addr", mem_addr, r_addr);
                chk("R8", "mem_src",  mem_src,  r_src);
            end
        end
        if (mem_rd && first_rd < 0) begin first_rd = mem_addr; first_src = mem_src; end
        if (mem_rd && !mem_src && mem_addr >= 12'h080) hit80 = 1;
        if (cfg_cclk) begin clk_total++; bitacc = {bitacc[62:0], cfg_din}; end
        if (err_flag) seen_err = 1;
        // device behaviour
        if (prev_prog && !cfg_prog_n) pcount++;
        if (!cfg_prog_n) begin since = 0; bits = 0; end
        else begin since++; if (cfg_cclk) bits++; end
        prev_prog = cfg_prog_n;
        li = (pcount >= 2) ? 1 : 0;
        if (cfg_prog_n && pcount > 0 && pcount <= 2 && since >= 2) begin
            cfg_init = init_ok[li] != 0;
            cfg_done = (done_ok[li] != 0) && bits >= need[li];
            cfg_err  = (err_bit[li] >= 0) && bits == err_bit[li];
        end else begin
            cfg_init = 0; cfg_done = 0; cfg_err = 0;
        end
    end

    task automatic wr_tbl(input int s, input int a);
        @(negedge clk); tbl_we = 1; tbl_slot = 2'(s); tbl_addr = AW'(a);
        @(negedge clk); tbl_we = 0;
    endtask

    task automatic run_load(input int slot, input int i0, input int d0, input int n0, input int e0,
                            input int i1, input int d1, input int n1, input int e1);
        int cyc;
        init_ok[0] = i0; done_ok[0] = d0; need[0] = n0; err_bit[0] = e0;
        init_ok[1] = i1; done_ok[1] = d1; need[1] = n1; err_bit[1] = e1;
        @(negedge clk);
        pcount = 0; first_rd = -1; first_src = -1; clk_total = 0; bitacc = 0;
        seen_err = 0; hit80 = 0;
        cmd_slot = 2'(slot); cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        chk("R13", "busy after start", busy, 1);
        cyc = 0;
        while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (cache_m[i]) cache_m[i] = 8'h00;
        foreach (flash_m[i]) flash_m[i] = 8'h00;
        cache_m[8'h10] = 8'h00; cache_m[8'h11] = 8'h03;
        cache_m[8'h12] = 8'hA5; cache_m[8'h13] = 8'h3C; cache_m[8'h14] = 8'h81;
        cache_m[8'h40] = 8'h00; cache_m[8'h41] = 8'h02;
        cache_m[8'h42] = 8'h0F; cache_m[8'h43] = 8'hF0;
        cache_m[8'h80] = 8'h00; cache_m[8'h81] = 8'h00;
        flash_m[8'h00] = 8'h00; flash_m[8'h01] = 8'h02;
        flash_m[8'h02] = 8'hC3; flash_m[8'h03] = 8'h5A;
        foreach (init_ok[i]) begin init_ok[i] = 1; done_ok[i] = 1; need[i] = 0; err_bit[i] = -1; end

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "prog_n", cfg_prog_n, 1); chk("R1", "cclk", cfg_cclk, 0);
        chk("R1", "din", cfg_din, 0);       chk("R1", "mem_rd", mem_rd, 0);
        chk("R1", "busy", busy, 0);         chk("R1", "loaded", loaded, 0);
        chk("R1", "fatal", fatal, 0);       chk("R1", "err_flag", err_flag, 0);
        rst_n = 1'b1; cmp_en = 1;
        @(negedge clk);
        chk("R1", "idle after reset", {busy, loaded, fatal, err_flag}, 0);

        wr_tbl(0, 'h10); wr_tbl(1, 'h40); wr_tbl(2, 'h80);
        wr_tbl(3, 'h40);  // R2: slot 3 does not exist

        // R2 R5 R7: clean load from slot 0
        run_load(0, 1, 1, 24, -1, 1, 1, 16, -1);
        chk("R2", "first read address", first_rd, 'h10);
        chk("R2", "first read source", first_src, 0);
        chk("R5", "bits sent MSB first", bitacc[23:0], 24'hA53C81);
        chk("R5", "clock pulses", clk_total, 24);
        chk("R7", "loaded", loaded, 1);
        chk("R13", "busy cleared", busy, 0);

        // R12: start while busy is ignored
        init_ok[0] = 1; done_ok[0] = 1; need[0] = 16; err_bit[0] = -1;
        @(negedge clk);
        pcount = 0; hit80 = 0; first_rd = -1;
        cmd_slot = 2'd1; cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        repeat (6) @(negedge clk);
        cmd_slot = 2'd2; cmd_start = 1;
        @(negedge clk); cmd_start = 0;
        while (busy) @(negedge clk);
        chk("R12", "no read of slot 2 image", hit80, 0);
        chk("R12", "first read slot 1", first_rd, 'h40);
        chk("R7", "loaded after slot 1", loaded, 1);

        // R4: zero-length image
        run_load(2, 1, 1, 0, -1, 1, 1, 16, -1);
        chk("R4", "no clock for empty image", clk_total, 0);
        chk("R4", "loaded", loaded, 1);
        chk("R4", "no error", err_flag, 0);

        // R8: done timeout, base image succeeds
        run_load(0, 1, 0, 24, -1, 1, 1, 16, -1);
        chk("R8", "error latched", err_flag, 1);
        chk("R8", "base image bits", bitacc[15:0], 16'hC35A);
        chk("R8", "loaded from base", loaded, 1);
        repeat (5) @(negedge clk);
        chk("R11", "flag holds", err_flag, 1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R11", "flag cleared", err_flag, 0);

        // R8: error mid-byte
        run_load(1, 1, 1, 16, 5, 1, 1, 16, -1);
        chk("R8", "error input fallback flag", err_flag, 1);
        chk("R8", "loaded after abort", loaded, 1);
        chk("R8", "base bits after abort", bitacc[15:0], 16'hC35A);
        err_clr = 1; @(negedge clk); err_clr = 0;

        // R3 R8: init timeout
        run_load(0, 0, 1, 0, -1, 1, 1, 16, -1);
        chk("R3", "init timeout fallback", err_flag, 1);
        chk("R8", "only base bits", clk_total, 16);
        err_clr = 1; @(negedge clk); err_clr = 0;

        // R9 R11: invalid slot with clear held high
        err_clr = 1;
        run_load(3, 1, 1, 16, -1, 1, 1, 16, -1);
        chk("R9", "reads flash", first_src, 1);
        chk("R9", "reads base address", first_rd, 0);
        chk("R11", "set wins over clear", seen_err, 1);
        chk("R9", "loaded", loaded, 1);
        err_clr = 0;
        run_load(3, 1, 1, 16, -1, 1, 1, 16, -1);
        chk("R9", "invalid slot flag", err_flag, 1);
        err_clr = 1; @(negedge clk); err_clr = 0;

        // R10: both loads fail
        run_load(0, 1, 0, 24, -1, 1, 0, 16, -1);
        chk("R10", "fatal", fatal, 1);
        chk("R10", "not busy", busy, 0);
        chk("R10", "not loaded", loaded, 0);
        run_load(1, 1, 1, 16, -1, 1, 1, 16, -1);
        chk("R10", "start leaves fatal", fatal, 0);
        chk("R10", "recovered", loaded, 1);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule